// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer arithmetic-logic unit built from a row of identical one-bit slices. Each slice conditions its operand bits (optional inversion of either operand), forms generate and propagate terms, and picks its result bit from an AND term, an OR term, the sum bit, or a "less" input. A ripple carry chain links the slices. Subtraction reuses the adder: operand b is inverted and the chain's initial carry is forced to one.

Set-on-less-than runs a subtraction. The signed comparison outcome, which is the difference's sign bit corrected by the overflow condition, is fed back into the "less" input of bit 0. Every other "less" input is tied low. Three flags go with the result: zero, signed overflow and carry-out. The block sits in an execute stage between the operand multiplexers and the result bus. It has no clock and holds no state.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of a and b, and 4'b0001 gives the bitwise OR.
- R2: Operation code 4'b1100 gives the bitwise NOR of a and b.
- R3: Operation code 4'b0010 gives a + b modulo 2^32, and carry_o is the carry out of bit 31 of that sum.
- R4: Operation code 4'b0110 gives a - b modulo 2^32, formed as a + ~b + 1, and carry_o is the carry out of bit 31 of that sum (1 when a >= b unsigned).
- R5: For add and subtract, overflow_o is 1 exactly when the two's-complement result has the wrong sign. This equals the XOR of the carries into and out of bit 31.
- R6: Operation code 4'b0111 gives 32'd1 when a < b as signed numbers and 32'd0 otherwise, and stays correct when a - b overflows. carry_o and overflow_o are 0 for this code.
- R7: zero_o is 1 exactly when all 32 result bits are 0, for every operation code.
- R8: For the logical codes and for all unlisted codes, carry_o and overflow_o are 0. Unlisted codes produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of the top slice for add or subtract |

## Verification
Several flags can respond to one operation at once. Adding the most-negative value to itself raises zero, carry and overflow together. Subtracting the most-positive value from the most-negative value overflows while set-on-less-than must still answer through the feedback path. The directed tasks apply exactly these operand pairs. Each flag and the result are judged against a reference model that uses the plain arithmetic operators, so a wrong flag cannot be hidden by a correct result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_AND  = 3'd0,
    SEL_OR   = 3'd1,
    SEL_SUM  = 3'd2,
    SEL_LESS = 3'd3,
    SEL_ZERO = 3'd4
  } res_sel_e;

  typedef struct packed {
    logic     a_inv;
    logic     b_inv;
    logic     carry_in;
    logic     arith;   // add/sub: flags visible
    res_sel_e sel;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o = '{a_inv: 1'b0, b_inv: 1'b0, carry_in: 1'b0, arith: 1'b0, sel: SEL_ZERO};
    case (op_i)
      OP_AND: ctrl_o.sel = SEL_AND;
      OP_OR:  ctrl_o.sel = SEL_OR;
      OP_NOR: begin
        // ~a & ~b
        ctrl_o.a_inv = 1'b1;
        ctrl_o.b_inv = 1'b1;
        ctrl_o.sel   = SEL_AND;
      end
      OP_ADD: begin
        ctrl_o.arith = 1'b1;
        ctrl_o.sel   = SEL_SUM;
      end
      OP_SUB: begin
        ctrl_o.b_inv    = 1'b1;
        ctrl_o.carry_in = 1'b1;
        ctrl_o.arith    = 1'b1;
        ctrl_o.sel      = SEL_SUM;
      end
      OP_SLT: begin
        ctrl_o.b_inv    = 1'b1;
        ctrl_o.carry_in = 1'b1;
        ctrl_o.sel      = SEL_LESS;
      end
      default: ctrl_o.sel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     a_inv_i,
  input  logic     b_inv_i,
  input  logic     carry_i,
  input  logic     less_i,
  input  res_sel_e sel_i,
  output logic     gen_o,
  output logic     prop_o,
  output logic     res_o
);
  logic a_c, b_c, sum;

  assign a_c    = a_i ^ a_inv_i;
  assign b_c    = b_i ^ b_inv_i;
  assign gen_o  = a_c & b_c;
  assign prop_o = a_c ^ b_c;
  assign sum    = prop_o ^ carry_i;

  always_comb begin
    case (sel_i)
      SEL_AND:  res_o = a_c & b_c;
      SEL_OR:   res_o = a_c | b_c;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  input  logic             carry_i,
  output logic [WIDTH:0]   carry_o
);
  always_comb begin
    carry_o[0] = carry_i;
    for (int i = 0; i < WIDTH; i++) begin
      carry_o[i+1] = gen_i[i] | (prop_i[i] & carry_o[i]);
    end
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             prop_msb_i,
  input  logic             carry_msb_i,  // into top slice
  input  logic             carry_out_i,  // out of top slice
  input  logic             arith_i,
  output logic             less_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  logic ovf_raw, sign_raw;

  assign ovf_raw    = carry_msb_i ^ carry_out_i;
  assign sign_raw   = prop_msb_i ^ carry_msb_i;
  assign less_o     = sign_raw ^ ovf_raw;  // signed compare survives overflow
  assign zero_o     = ~|result_i;
  assign overflow_o = arith_i & ovf_raw;
  assign carry_o    = arith_i & carry_out_i;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] gen, prop;
  logic [WIDTH:0]   carry;
  logic             set_bit;

  alu_op_decode u_decode (
    .op_i  (op_i),
    .ctrl_o(ctrl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .a_inv_i(ctrl.a_inv),
      .b_inv_i(ctrl.b_inv),
      .carry_i(carry[i]),
      .less_i (less_in),
      .sel_i  (ctrl.sel),
      .gen_o  (gen[i]),
      .prop_o (prop[i]),
      .res_o  (result_o[i])
    );
  end

  alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .gen_i  (gen),
    .prop_i (prop),
    .carry_i(ctrl.carry_in),
    .carry_o(carry)
  );

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .result_i   (result_o),
    .prop_msb_i (prop[MSB]),
    .carry_msb_i(carry[MSB]),
    .carry_out_i(carry[WIDTH]),
    .arith_i    (ctrl.arith),
    .less_o     (set_bit),
    .zero_o     (zero_o),
    .overflow_o (overflow_o),
    .carry_o    (carry_o)
  );

  // Checks against plain arithmetic, guarded against undriven inputs
  logic [WIDTH:0] add_wide, sub_wide;
  assign add_wide = {1'b0, a_i} + {1'b0, b_i};
  assign sub_wide = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      if (op_i == OP_ADD) begin
        p_add_sum_r3:   assert (result_o == add_wide[MSB:0]);
        p_add_carry_r3: assert (carry_o == add_wide[WIDTH]);
        p_add_ovf_r5:   assert (overflow_o ==
                               ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])));
      end
      if (op_i == OP_SUB) begin
        p_sub_diff_r4:  assert (result_o == a_i - b_i);
        p_sub_carry_r4: assert (carry_o == (a_i >= b_i));
        p_sub_ovf_r5:   assert (overflow_o ==
                               ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])));
      end
      if (op_i == OP_SLT) begin
        p_slt_value_r6: assert (result_o == {{MSB{1'b0}}, ($signed(a_i) < $signed(b_i))});
        p_slt_flags_r6: assert (!carry_o && !overflow_o);
      end
      p_zero_flag_r7: assert (zero_o == (result_o == '0));
      if (op_i == OP_AND || op_i == OP_OR || op_i == OP_NOR) begin
        p_logic_flags_r8: assert (!carry_o && !overflow_o);
      end
    end
  end
endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
  localparam int unsigned W = 32;
  localparam logic [W-1:0] MIN_NEG = 32'h8000_0000;
  localparam logic [W-1:0] MAX_POS = 32'h7FFF_FFFF;
  localparam logic [W-1:0] ALL_ONE = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [3:0]   op;
  logic [W-1:0] a, b, result;
  logic         zero, ovf, carry;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bitslice_alu dut (
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .result_o  (result),
    .zero_o    (zero),
    .overflow_o(ovf),
    .carry_o   (carry)
  );

  // Reference: {result, zero, overflow, carry}
  function automatic logic [W+2:0] ref_alu(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    logic [W:0]   wide;
    logic         v, c;
    r = '0; v = 1'b0; c = 1'b0;
    case (o)
      4'b0000: r = x & y;
      4'b0001: r = x | y;
      4'b1100: r = ~(x | y);
      4'b0010: begin
        wide = {1'b0, x} + {1'b0, y};
        r = wide[W-1:0]; c = wide[W];
        v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
      end
      4'b0110: begin
        r = x - y; c = (x >= y);
        v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
      end
      4'b0111: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    return {r, (r == '0), v, c};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    logic [W+2:0] exp;
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    exp = ref_alu(o, x, y);
    checks++;
    if ({result, zero, ovf, carry} !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h got res=%h z=%b v=%b c=%b exp res=%h z=%b v=%b c=%b",
               tag, o, x, y, result, zero, ovf, carry,
               exp[W+2:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic t_reset_state();
    apply(4'b0000, '0, '0, "R7 idle");
  endtask

  task automatic t_logic();
    apply(4'b0000, 32'hF0F0_A5A5, 32'hFF00_5A5A, "R1 and");
    apply(4'b0001, 32'hF0F0_A5A5, 32'h0F0F_0000, "R1 or");
    apply(4'b0000, ALL_ONE, MIN_NEG, "R1 and msb");
    apply(4'b1100, 32'h1234_0000, 32'h0000_5678, "R2 nor");
    apply(4'b1100, '0, '0, "R2 nor zeros");
    apply(4'b1100, ALL_ONE, '0, "R2 nor gives zero R7");
  endtask

  task automatic t_add();
    apply(4'b0010, 32'd5, 32'd7, "R3 add small");
    apply(4'b0010, ALL_ONE, 32'd1, "R3 add carry wrap R7");
    apply(4'b0010, MAX_POS, 32'd1, "R5 add pos ovf");
    apply(4'b0010, MIN_NEG, MIN_NEG, "R5 add neg ovf zero carry");
    apply(4'b0010, MIN_NEG, ALL_ONE, "R5 add neg ovf");
  endtask

  task automatic t_sub();
    apply(4'b0110, 32'd9, 32'd4, "R4 sub pos");
    apply(4'b0110, 32'd4, 32'd9, "R4 sub borrow");
    apply(4'b0110, 32'd77, 32'd77, "R4 sub equal R7");
    apply(4'b0110, MIN_NEG, 32'd1, "R5 sub ovf");
    apply(4'b0110, MAX_POS, ALL_ONE, "R5 sub ovf pos");
    apply(4'b0110, '0, '0, "R4 sub zero");
  endtask

  task automatic t_slt();
    apply(4'b0111, 32'd3, 32'd8, "R6 slt true");
    apply(4'b0111, 32'd8, 32'd3, "R6 slt false");
    apply(4'b0111, ALL_ONE, 32'd0, "R6 slt neg");
    apply(4'b0111, 32'd5, 32'd5, "R6 slt equal");
    apply(4'b0111, MIN_NEG, MAX_POS, "R6 slt ovf true");
    apply(4'b0111, MAX_POS, MIN_NEG, "R6 slt ovf false");
    apply(4'b0111, MIN_NEG, 32'd1, "R6 slt ovf min");
  endtask

  task automatic t_unlisted();
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code;
      code = c[3:0];
      if (code inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}) continue;
      apply(code, ALL_ONE, MAX_POS, "R8 unlisted");
    end
  endtask

  task automatic t_random();
    logic [3:0] codes[6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    logic [W-1:0] edges[4] = '{'0, ALL_ONE, MIN_NEG, MAX_POS};
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 4; j++) begin
        for (int k = 0; k < 4; k++) begin
          apply(codes[i], edges[j], edges[k], "R1 R3 R4 R6 edge");
        end
      end
    end
    for (int n = 0; n < 600; n++) begin
      apply(codes[n % 6], $urandom(), $urandom(), "R2 R5 R7 R8 random");
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_unlisted();
    t_random();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule